// File: doc/BRIEF.md
# Memory-Mapped NAND Command Bridge

This block lets a host on a simple memory-mapped request channel drive an 8-bit NAND device port. The host address does two jobs. In the NAND window it selects the chip select, a secondary die select, and the cycle type: command latch, address latch or data transfer. In the register window it reaches three small registers: a chip-select enable mask, a ready status and a read-only revision.

A host request may be one, two or four bytes wide. The block turns it into that many NAND byte cycles, least significant byte first. Each byte cycle has a fixed setup phase, strobe phase and hold phase. The request channel uses valid/ready. The host raises `req_valid` and holds every request field steady. The bridge raises `req_ready` for exactly one cycle, and only once the last byte cycle has finished. In that same cycle `req_rdata` carries the read result. This back-pressure is the only flow control the block has.

All devices share one active-low busy line, wired-AND onto `nand_wait`. It passes through a two-flop synchroniser before it reaches the status register.

Top module: `nand_host_bridge`

## Requirements
- R1: In a NAND-window access (`req_addr[15]`=0) with `req_addr[4]`=1, `nand_cle` is high and `nand_ale` is low in every byte cycle, whatever `req_addr[3]` holds.
- R2: With `req_addr[4]`=0, `nand_ale` equals `req_addr[3]` during the byte cycles, and `nand_cle` stays low, so with both bits clear the cycle is a plain data transfer.
- R3: `req_addr[1:0]` have no effect on any NAND pin, on the number of cycles or on read data.
- R4: `req_size` 0, 1 and 2 or 3 give 1, 2 and 4 byte cycles. Each byte cycle is SETUP (1), STROBE (2) and HOLD (1) clocks, with the strobe low only in the STROBE clocks. A write puts byte k of `req_wdata` (bits 8k+7:8k) on `nand_dq_out`, byte 0 first, with `nand_we_n` as the strobe and `nand_dq_oe` high.
- R5: A read strobes `nand_re_n` and samples `nand_dq_in` in the last STROBE clock of byte cycle k into `req_rdata[8k+7:8k]`. Bytes not transferred read as zero.
- R6: `req_addr[14:13]` pick which bit of `nand_ce_n` goes low during the byte cycles. At most one bit is ever low, and only a chip select whose enable bit is set is ever driven.
- R7: A NAND-window access to a chip select whose enable bit is clear produces no NAND cycle, completes one cycle after acceptance and reads zero.
- R8: `nand_sec_sel` equals `req_addr[12]` during the byte cycles and is low otherwise.
- R9: `req_ready` is high for a single cycle. It comes N·4+1 cycles after acceptance for an N-byte NAND access, and 1 cycle after acceptance for a register access. After reset `req_ready` is low, all `nand_ce_n` are high and both strobes are high.
- R10: The enable register at offset 0x0 of the register window (`req_addr[15]`=1, offset `req_addr[3:2]`) holds bit n for chip select n. It resets to 0, keeps only bits 3:0 on a write and reads other bits as 0.
- R11: The status register at offset 0x4 shows bit 0 = `nand_wait` delayed by two clocks (1 = ready), with all other bits 0.
- R12: The revision register at offset 0x8 reads major revision 0x02 in bits 15:8 and minor revision 0x05 in bits 7:0. A write to it has no effect. Offset 0xC reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request completed (one-cycle pulse) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address: window, chip select, die, cycle type |
| req_size | input | 2 | 0 = byte, 1 = halfword, 2/3 = word |
| req_wdata | input | 32 | Write data |
| req_rdata | output | 32 | Read data, valid with req_ready |
| nand_ce_n | output | 4 | Active-low chip selects |
| nand_sec_sel | output | 1 | Secondary die select |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data to device |
| nand_dq_oe | output | 1 | Data output enable |
| nand_dq_in | input | 8 | Data from device |
| nand_wait | input | 1 | Wired-AND ready/busy, 1 = ready |

## Verification
The assertions assume the host follows the request rule. Once `req_valid` is high, it and the address, size, direction and write data stay unchanged until `req_ready` is seen. The NAND pins are decoded directly from those held fields. The bench's access task raises all fields together at a falling edge and keeps them until the ready pulse has been taken. It then drops `req_valid`, so the held-request assertion is never violated by the stimulus. The device model changes `nand_dq_in` only at the falling edge that opens a read strobe, which keeps the data steady through the sampling edge.

// File: rtl/nand_bridge_pkg.sv
`timescale 1ns/1ps
package nand_bridge_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_FIN} br_state_t;
  typedef enum logic [1:0] {PH_SETUP, PH_STROBE, PH_HOLD} byte_phase_t;

  // index of the final byte lane for a given host access size
  function automatic logic [1:0] last_lane(input logic [1:0] size);
    case (size)
      2'd0:    last_lane = 2'd0;
      2'd1:    last_lane = 2'd1;
      default: last_lane = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/nand_wait_sync.sv
`timescale 1ns/1ps
module nand_wait_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_i,
  output logic ready_o
);
  logic stage1, stage2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= 1'b0;
      stage2 <= 1'b0;
    end else begin
      stage1 <= wait_i;
      stage2 <= stage1;
    end
  end
  assign ready_o = stage2;

  // checker age: counts edges since reset, saturating at two
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R11: status bit is the wait input two clocks late
  a_r11_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (ready_o == $past(wait_i, 2)));
endmodule

// File: rtl/nand_byte_seq.sv
`timescale 1ns/1ps
module nand_byte_seq
  import nand_bridge_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC   = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] last_idx,
  output logic       active,
  output logic       strobe,
  output logic       capture,
  output logic [1:0] byte_idx,
  output logic       done
);
  localparam int MAX_SP  = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_LEN = (MAX_SP > HOLD_CYC) ? MAX_SP : HOLD_CYC;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  byte_phase_t      phase;
  logic [CNT_W-1:0] cnt, phase_last;
  logic             phase_end;

  always_comb begin
    case (phase)
      PH_SETUP:  phase_last = CNT_W'(SETUP_CYC - 1);
      PH_STROBE: phase_last = CNT_W'(STROBE_CYC - 1);
      default:   phase_last = CNT_W'(HOLD_CYC - 1);
    endcase
  end
  assign phase_end = (cnt == phase_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      phase    <= PH_SETUP;
      cnt      <= '0;
      byte_idx <= 2'd0;
    end else if (!active) begin
      if (start) begin
        active   <= 1'b1;
        phase    <= PH_SETUP;
        cnt      <= '0;
        byte_idx <= 2'd0;
      end
    end else if (!phase_end) begin
      cnt <= cnt + 1'b1;
    end else begin
      cnt <= '0;
      case (phase)
        PH_SETUP:  phase <= PH_STROBE;
        PH_STROBE: phase <= PH_HOLD;
        default: begin
          phase <= PH_SETUP;
          if (byte_idx == last_idx) active <= 1'b0;
          else byte_idx <= byte_idx + 2'd1;
        end
      endcase
    end
  end

  assign strobe  = active && (phase == PH_STROBE);
  assign capture = strobe && phase_end;
  assign done    = active && (phase == PH_HOLD) && phase_end && (byte_idx == last_idx);

  // R4: the byte lane never runs past the size the host asked for
  a_r4_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (byte_idx <= last_idx));
endmodule

// File: rtl/nand_bridge_regs.sv
`timescale 1ns/1ps
module nand_bridge_regs #(
  parameter int         NUM_CS    = 4,
  parameter logic [7:0] REV_MAJOR = 8'h02,
  parameter logic [7:0] REV_MINOR = 8'h05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        offset,
  input  logic [31:0]       wr_data,
  input  logic              dev_ready,
  output logic [31:0]       rd_data,
  output logic [NUM_CS-1:0] cs_enable
);
  logic unused_wr_hi;
  assign unused_wr_hi = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) cs_enable <= '0;
    else if (wr_en && offset == 2'd0) cs_enable <= wr_data[NUM_CS-1:0];
  end

  always_comb begin
    case (offset)
      2'd0:    rd_data = 32'(cs_enable);
      2'd1:    rd_data = {31'b0, dev_ready};
      2'd2:    rd_data = {16'b0, REV_MAJOR, REV_MINOR};
      default: rd_data = 32'b0;
    endcase
  end

  // R10: the enable mask only moves on a register write
  a_r10_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cs_enable));
endmodule

// File: rtl/nand_host_bridge.sv
`timescale 1ns/1ps
module nand_host_bridge
  import nand_bridge_pkg::*;
#(
  parameter int         ADDR_W     = 16,
  parameter int         NUM_CS     = 4,
  parameter int         ALE_BIT    = 3,
  parameter int         CLE_BIT    = 4,
  parameter int         SEC_BIT    = 12,
  parameter int         CS_LSB     = 13,
  parameter int         REG_BIT    = 15,
  parameter int         SETUP_CYC  = 1,
  parameter int         STROBE_CYC = 2,
  parameter int         HOLD_CYC   = 1,
  parameter logic [7:0] REV_MAJOR  = 8'h02,
  parameter logic [7:0] REV_MINOR  = 8'h05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       req_rdata,
  output logic [NUM_CS-1:0] nand_ce_n,
  output logic              nand_sec_sel,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [7:0]        nand_dq_in,
  input  logic              nand_wait
);
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  br_state_t         state;
  logic [31:0]       rd_buf, reg_rd;
  logic [NUM_CS-1:0] cs_en;
  logic [CS_W-1:0]   cs_sel;
  logic              dev_ready, is_reg, cs_hit, accept, seq_start;
  logic              seq_active, seq_strobe, seq_cap, seq_done;
  logic [1:0]        byte_idx, last_idx;
  logic              unused_addr;

  assign unused_addr = ^req_addr;
  assign cs_sel      = req_addr[CS_LSB +: CS_W];
  assign is_reg      = req_addr[REG_BIT];
  assign cs_hit      = (int'(cs_sel) < NUM_CS) && cs_en[cs_sel];
  assign accept      = (state == ST_IDLE) && req_valid;
  assign seq_start   = accept && !is_reg && cs_hit;
  assign last_idx    = last_lane(req_size);

  nand_wait_sync u_sync (
    .clk(clk), .rst_n(rst_n), .wait_i(nand_wait), .ready_o(dev_ready)
  );

  nand_bridge_regs #(.NUM_CS(NUM_CS), .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(accept && is_reg && req_write),
    .offset(req_addr[3:2]), .wr_data(req_wdata),
    .dev_ready(dev_ready), .rd_data(reg_rd), .cs_enable(cs_en)
  );

  nand_byte_seq #(.SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .last_idx(last_idx),
    .active(seq_active), .strobe(seq_strobe), .capture(seq_cap),
    .byte_idx(byte_idx), .done(seq_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      rd_buf <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          rd_buf <= (is_reg && !req_write) ? reg_rd : 32'b0;
          state  <= seq_start ? ST_XFER : ST_FIN;
        end
        ST_XFER: begin
          if (seq_cap && !req_write) rd_buf[{byte_idx, 3'b000} +: 8] <= nand_dq_in;
          if (seq_done) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_FIN);
  assign req_rdata = rd_buf;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_ce
    assign nand_ce_n[i] = !(seq_active && (cs_sel == CS_W'(i)));
  end

  assign nand_cle     = seq_active && req_addr[CLE_BIT];
  assign nand_ale     = seq_active && !req_addr[CLE_BIT] && req_addr[ALE_BIT];
  assign nand_sec_sel = seq_active && req_addr[SEC_BIT];
  assign nand_we_n    = !(seq_strobe && req_write);
  assign nand_re_n    = !(seq_strobe && !req_write);
  assign nand_dq_oe   = seq_active && req_write;
  assign nand_dq_out  = req_wdata[{byte_idx, 3'b000} +: 8];

  // R9: host keeps the request unchanged until it is completed
  a_r9_host_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_size)
                                   && $stable(req_write) && $stable(req_wdata)));
  // R9: completion is a single-cycle pulse
  a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
  // R6: never more than one chip select low
  a_r6_ce_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~nand_ce_n));
  // R6: only enabled chip selects are driven
  a_r6_ce_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    ((~nand_ce_n) & ~cs_en) == '0);
  // R4: write data is already set up when the strobe falls and holds through it
  a_r4_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> $stable(nand_dq_out));
endmodule

// File: tb/nand_host_bridge_tb.sv
`timescale 1ns/1ps
module nand_host_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready;
  logic [31:0] req_rdata;
  logic [3:0]  nand_ce_n;
  logic        nand_sec_sel, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out;
  logic [7:0]  nand_dq_in = '0;
  logic        nand_wait = 1'b1;

  always #4 clk = ~clk;

  nand_host_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .req_rdata(req_rdata), .nand_ce_n(nand_ce_n),
    .nand_sec_sel(nand_sec_sel), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_wait(nand_wait)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // device-side monitor, sampled at falling edges
  int         ev_cnt = 0, act_cyc = 0;
  logic [7:0] ev_data [8];
  logic [3:0] ev_ce   [8];
  logic       ev_cle  [8], ev_ale [8], ev_sec [8], ev_wr [8], ev_oe [8];
  int         ev_len  [8];
  logic       prev_strb = 1'b0;
  logic [7:0] seed = '0;

  function automatic logic [7:0] dev_byte(input logic [7:0] s, input int k);
    return 8'(8'hC3 ^ (s * 8'd7 + 8'(k * 29)));
  endfunction

  always @(negedge clk) begin
    logic strb;
    strb = !nand_we_n || !nand_re_n;
    if (nand_ce_n != 4'hF) act_cyc++;
    if (strb && !prev_strb && ev_cnt < 8) begin
      ev_data[ev_cnt] = nand_dq_out;
      ev_ce[ev_cnt]   = nand_ce_n;
      ev_cle[ev_cnt]  = nand_cle;
      ev_ale[ev_cnt]  = nand_ale;
      ev_sec[ev_cnt]  = nand_sec_sel;
      ev_wr[ev_cnt]   = !nand_we_n;
      ev_oe[ev_cnt]   = nand_dq_oe;
      ev_len[ev_cnt]  = 1;
      if (!nand_re_n) nand_dq_in = dev_byte(seed, ev_cnt);
      ev_cnt++;
    end else if (strb && ev_cnt > 0) begin
      ev_len[ev_cnt-1]++;
    end
    prev_strb = strb;
  end

  task automatic access(input bit wr, input logic [15:0] addr, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk);
    ev_cnt = 0; act_cyc = 0;
    req_write = wr; req_addr = addr; req_size = sz; req_wdata = wd; req_valid = 1'b1;
    lat = 0;
    do begin
      @(posedge clk); @(negedge clk); lat++;
    end while (!req_ready && lat < 400);
    rd = req_rdata;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL R9: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state at the ports
    chk(req_ready == 1'b0, "R9 reset ready", 32'(req_ready), 0);
    chk(nand_ce_n == 4'hF, "R6 reset ce", 32'(nand_ce_n), 32'hF);
    chk(nand_we_n && nand_re_n && !nand_dq_oe, "R9 reset strobes",
        {29'b0, nand_we_n, nand_re_n, nand_dq_oe}, 32'h6);

    // R10: mask resets to zero, keeps only bits 3:0
    access(0, 16'h8000, 2, 0, rd, lat);
    chk(rd == 0, "R10 reset mask", rd, 0);
    chk(lat == 1, "R9 register latency", 32'(lat), 1);
    // R7: every chip select disabled: no cycles, reads zero
    access(0, 16'h0000, 2, 0, rd, lat);
    chk(ev_cnt == 0 && act_cyc == 0, "R7 no cycles when disabled", 32'(ev_cnt + act_cyc), 0);
    chk(rd == 0 && lat == 1, "R7 disabled completes", rd, 0);
    access(1, 16'h8000, 2, 32'hFFFF_FFF5, rd, lat);
    access(0, 16'h8000, 2, 0, rd, lat);
    chk(rd == 32'h5, "R10 mask write", rd, 32'h5);
    access(0, 16'h2000, 0, 0, rd, lat);   // cs1 disabled
    chk(ev_cnt == 0 && act_cyc == 0 && rd == 0 && lat == 1, "R7 cs1 disabled",
        32'(ev_cnt), 0);
    access(1, 16'h6000, 0, 32'hAB, rd, lat);   // cs3 disabled
    chk(ev_cnt == 0 && lat == 1, "R7 cs3 disabled write", 32'(ev_cnt), 0);
    access(1, 16'h4000, 0, 32'h3C, rd, lat);   // cs2 enabled
    chk(ev_cnt == 1 && ev_ce[0] == 4'b1011 && ev_data[0] == 8'h3C, "R6 cs2 enabled",
        {24'b0, ev_data[0]}, 32'h3C);

    // R12: revision, write ignored, offset 0xC
    access(0, 16'h8008, 2, 0, rd, lat);
    chk(rd == 32'h0205, "R12 revision", rd, 32'h0205);
    access(1, 16'h8008, 2, 32'hFFFF_FFFF, rd, lat);
    access(0, 16'h8008, 2, 0, rd, lat);
    chk(rd == 32'h0205, "R12 revision write ignored", rd, 32'h0205);
    access(0, 16'h800C, 2, 0, rd, lat);
    chk(rd == 0, "R12 offset C", rd, 0);

    // R11: status follows wait two clocks late
    nand_wait = 1'b0;
    repeat (4) @(negedge clk);
    access(0, 16'h8004, 2, 0, rd, lat);
    chk(rd == 0, "R11 busy", rd, 0);
    @(negedge clk);
    nand_wait = 1'b1;
    access(0, 16'h8004, 2, 0, rd, lat);
    chk(rd == 0, "R11 sync delay", rd, 0);
    access(0, 16'h8004, 2, 0, rd, lat);
    chk(rd == 1, "R11 ready", rd, 1);

    // enable all four chip selects
    access(1, 16'h8000, 2, 32'hF, rd, lat);

    // sweep: direction x size x cycle type x chip select x die x low bits
    for (int wr = 0; wr < 2; wr++)
      for (int sz = 0; sz < 3; sz++)
        for (int kind = 0; kind < 4; kind++)
          for (int cs = 0; cs < 4; cs++)
            for (int sec = 0; sec < 2; sec++)
              for (int lowb = 0; lowb < 4; lowb++) begin
                int          nb;
                logic [31:0] wd, exp_rd;
                logic [15:0] a;
                bit          ok_d, ok_c, ok_t;
                nb   = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
                seed = seed + 8'd1;
                wd   = 32'(seed) * 32'h01F3_A715 + 32'h1357_9BDF;
                a    = 16'((cs << 13) | (sec << 12) | (kind << 3) | lowb);
                access(wr[0], a, 2'(sz), wd, rd, lat);
                // R4: byte cycle count, timing and lane order; R3 low bits ignored
                chk(ev_cnt == nb, "R4/R3 byte cycle count", 32'(ev_cnt), 32'(nb));
                chk(act_cyc == nb * 4, "R4 cycle length", 32'(act_cyc), 32'(nb * 4));
                chk(lat == nb * 4 + 1, "R9 NAND latency", 32'(lat), 32'(nb * 4 + 1));
                ok_d = 1; ok_c = 1; ok_t = 1;
                exp_rd = 0;
                for (int k = 0; k < nb && k < ev_cnt; k++) begin
                  exp_rd[8*k +: 8] = dev_byte(seed, k);
                  if (wr == 1 && ev_data[k] != wd[8*k +: 8]) ok_d = 0;
                  if (ev_cle[k] != kind[1]) ok_c = 0;
                  if (ev_ale[k] != (kind == 1)) ok_c = 0;
                  if (ev_ce[k] != ~(4'b1 << cs) || ev_sec[k] != sec[0]) ok_t = 0;
                  if (ev_len[k] != 2 || ev_wr[k] != wr[0] || ev_oe[k] != wr[0]) ok_t = 0;
                end
                chk(ok_d, "R4 write byte order", 32'(ok_d), 1);
                chk(ok_c, kind[1] ? "R1 command latch" : "R2 address/data latch",
                    32'(ok_c), 1);
                chk(ok_t, "R6/R8 select, die and strobe", 32'(ok_t), 1);
                if (wr == 0) chk(rd == exp_rd, "R5 read assembly", rd, exp_rd);
              end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule